// File: doc/BRIEF.md
# Multi-Lane Direct Digital Synthesizer with Sync Muting

This block generates a sine wave for a converter whose sample clock runs a fixed multiple faster than the core clock. In every core cycle it delivers one sample for each sample-clock slot. Each sample is taken from its own phase accumulator. Neighbouring lanes sit one tuning word apart in phase, and every lane advances by the lane count times the tuning word per core cycle. Read in lane order, the parallel bus is therefore one continuous high-rate waveform.

A sync input restarts the waveform cleanly. While sync is high, the whole output bus is held at zero. When sync is released, all accumulators are seeded together from the initial-phase input. If the sync pulse was too short, an internal copy of sync is stretched until it has lasted at least the lane count in core cycles, so that no lane is left unaligned. Phase-to-amplitude conversion uses a quarter-wave sine table. A register stage sits after the table, so the bus stays at zero for one cycle after the seeding edge.

Top module: `dds_multilane`

## Requirements
- R1: `sample_o` carries LANES signed two's-complement samples of AMP_W bits each. Lane k sits in bits [k*AMP_W +: AMP_W], and lane 0 is the earliest in time.
- R2: On the seeding edge, lane k's phase becomes `phase_init_i + k*tune_i` modulo 2^PHASE_W. This is the first value shown after the seeding edge.
- R3: After seeding, every lane advances by LANES*`tune_i` per core cycle. The n-th shown sample of lane k is therefore at phase init + (k + LANES*n)*tune.
- R4: A lane's sample is round(32767*sin(2*pi*(a+0.5)/1024)) within 1 LSB, where a is the top 10 bits of its 16-bit phase.
- R5: In any cycle where `sync_i` is high, every lane of `sample_o` is zero in that same cycle.
- R6: Seeding happens on the first clock edge that samples `sync_i` low once the internal sync is allowed to end. The output stays zero after that edge, and the first sample appears after the following edge.
- R7: The internal sync lasts at least SYNC_MIN cycles. For a pulse seen high on P consecutive edges, the seeding edge is max(P, SYNC_MIN) edges after the first high edge, and the output stays zero until then.
- R8: While `rst_n` is low, `sample_o` is zero. The first edge after reset is released with `sync_i` low acts as a seeding edge.
- R9: Phase arithmetic wraps modulo 2^16 with no saturation, so a seed near full scale continues smoothly through zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Active-high restart and mute request |
| tune_i | input | PHASE_W | Phase increment per sample slot |
| phase_init_i | input | PHASE_W | Phase of lane 0 at seeding |
| sample_o | output | LANES*AMP_W | Parallel samples, lane 0 in the low bits |

## Verification
Two functions can land in the same cycle: muting on a new sync request, and the free-running advance of already seeded lanes. The bench raises sync while the lanes are streaming, and expects zero on every lane in that same cycle, even though the pipeline still holds valid data. Seeding and stretching also overlap. Pulses shorter than, equal to and longer than SYNC_MIN are each followed cycle by cycle, and the bench judges that the output is zero up to and including the computed seeding edge, and that the lane phases from the following edge match the init-plus-offset model.

// File: rtl/dds_pkg.sv
package dds_pkg;

    localparam real PI_R = 3.14159265358979323846;

    // Quarter-wave magnitude for table slot i, sampled at slot centres.
    function automatic int quarter_amp(input int i, input int qdepth, input int amax);
        real x;
        x = amax * $sin((PI_R / 2.0) * (i + 0.5) / qdepth);
        return $rtoi(x + 0.5);
    endfunction

endpackage

// File: rtl/dds_sync_ctrl.sv
module dds_sync_ctrl #(
    parameter int SYNC_MIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    output logic hold_next_o,
    output logic load_o
);
    localparam int CNT_W = $clog2(SYNC_MIN + 1);

    typedef struct packed {
        logic             hold;
        logic [CNT_W-1:0] cnt;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.hold = sync_i || (st_q.hold && (st_q.cnt < CNT_W'(SYNC_MIN)));
        if (!st_d.hold) begin
            st_d.cnt = '0;
        end else if (!st_q.hold) begin
            st_d.cnt = CNT_W'(1);
        end else if (st_q.cnt != CNT_W'(SYNC_MIN)) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.hold <= 1'b1;
            st_q.cnt  <= CNT_W'(SYNC_MIN);
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_next_o = st_d.hold;
    assign load_o      = st_q.hold && !st_d.hold;

    // R5
    sync_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> st_q.hold);

    // R7
    min_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.hold) |-> ($past(st_q.cnt) >= CNT_W'(SYNC_MIN)));

endmodule

// File: rtl/dds_phase_bank.sv
module dds_phase_bank #(
    parameter int LANES   = 4,
    parameter int PHASE_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load_i,
    input  logic                          hold_next_i,
    input  logic [PHASE_W-1:0]            tune_i,
    input  logic [PHASE_W-1:0]            phase_init_i,
    output logic [LANES-1:0][PHASE_W-1:0] phase_o,
    output logic                          valid_o
);
    typedef struct packed {
        logic                          valid;
        logic [LANES-1:0][PHASE_W-1:0] acc;
    } bank_t;

    bank_t st_d, st_q;
    logic [PHASE_W-1:0]            stride;
    logic [LANES-1:0][PHASE_W-1:0] seed;

    assign stride = PHASE_W'(LANES) * tune_i;

    for (genvar k = 0; k < LANES; k++) begin : g_seed
        assign seed[k] = phase_init_i + PHASE_W'(k) * tune_i;
    end

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.valid = 1'b1;
            st_d.acc   = seed;
        end else if (hold_next_i) begin
            st_d.valid = 1'b0;
        end else if (st_q.valid) begin
            for (int k = 0; k < LANES; k++) begin
                st_d.acc[k] = st_q.acc[k] + stride;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.acc;
    assign valid_o = st_q.valid;

    // R2
    seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.valid) |-> (st_q.acc[LANES-1] ==
            $past(phase_init_i) + PHASE_W'(LANES-1) * $past(tune_i)));

    // R3
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && $past(st_q.valid)) |->
            (st_q.acc[0] == $past(st_q.acc[0]) + PHASE_W'(LANES) * $past(tune_i)));

endmodule

// File: rtl/dds_sine_lut.sv
module dds_sine_lut #(
    parameter int ADDR_W = 10,
    parameter int AMP_W  = 16
) (
    input  logic [ADDR_W-1:0]       addr_i,
    output logic signed [AMP_W-1:0] amp_o
);
    localparam int IDX_W  = ADDR_W - 2;
    localparam int QDEPTH = 1 << IDX_W;
    localparam int AMAX   = (1 << (AMP_W - 1)) - 1;

    logic [AMP_W-2:0] qtab [QDEPTH];

    for (genvar i = 0; i < QDEPTH; i++) begin : g_tab
        localparam int QV = dds_pkg::quarter_amp(i, QDEPTH, AMAX);
        assign qtab[i] = (AMP_W-1)'(QV);
    end

    logic [1:0]             quad;
    logic [IDX_W-1:0]       idx;
    logic signed [AMP_W-1:0] mag;

    always_comb begin
        quad  = addr_i[ADDR_W-1 -: 2];
        idx   = quad[0] ? ~addr_i[IDX_W-1:0] : addr_i[IDX_W-1:0];
        mag   = signed'({1'b0, qtab[idx]});
        amp_o = quad[1] ? -mag : mag;
    end

endmodule

// File: rtl/dds_multilane.sv
module dds_multilane #(
    parameter int LANES    = 4,
    parameter int PHASE_W  = 16,
    parameter int LUT_AW   = 10,
    parameter int AMP_W    = 16,
    parameter int SYNC_MIN = LANES
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sync_i,
    input  logic [PHASE_W-1:0]       tune_i,
    input  logic [PHASE_W-1:0]       phase_init_i,
    output logic [LANES*AMP_W-1:0]   sample_o
);
    localparam int BUS_W = LANES * AMP_W;

    logic                          hold_next, load;
    logic [LANES-1:0][PHASE_W-1:0] phase;
    logic                          bank_valid;
    logic [LANES-1:0][AMP_W-1:0]   amp;

    dds_sync_ctrl #(.SYNC_MIN(SYNC_MIN)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_i     (sync_i),
        .hold_next_o(hold_next),
        .load_o     (load)
    );

    dds_phase_bank #(.LANES(LANES), .PHASE_W(PHASE_W)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .hold_next_i (hold_next),
        .tune_i      (tune_i),
        .phase_init_i(phase_init_i),
        .phase_o     (phase),
        .valid_o     (bank_valid)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic signed [AMP_W-1:0] lane_amp;
        dds_sine_lut #(.ADDR_W(LUT_AW), .AMP_W(AMP_W)) u_lut (
            .addr_i(phase[k][PHASE_W-1 -: LUT_AW]),
            .amp_o (lane_amp)
        );
        assign amp[k] = lane_amp;
    end

    typedef struct packed {
        logic             valid;
        logic [BUS_W-1:0] data;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d.valid = bank_valid && !hold_next;
        out_d.data  = amp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign sample_o = (out_q.valid && !sync_i) ? out_q.data : '0;

    // R6
    mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_q.valid |-> (sample_o == '0));

endmodule

// File: tb/sim_dds_multilane.sv
module sim_dds_multilane;
    localparam int LANES = 4;
    localparam int PW    = 16;
    localparam int AW    = 16;
    localparam int SMIN  = LANES;
    localparam int RUN   = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sync_i = 1'b0;
    logic [PW-1:0]     tune_i = '0;
    logic [PW-1:0]     phase_init_i = '0;
    logic [LANES*AW-1:0] sample_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    dds_multilane #(.LANES(LANES), .PHASE_W(PW), .LUT_AW(10), .AMP_W(AW), .SYNC_MIN(SMIN)) u0 (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .tune_i(tune_i),
        .phase_init_i(phase_init_i), .sample_o(sample_o)
    );

    function automatic int ref_amp(input logic [PW-1:0] ph);
        int  a;
        real x;
        a = int'(ph[PW-1 -: 10]);
        x = 32767.0 * $sin(2.0 * 3.14159265358979323846 * (a + 0.5) / 1024.0);
        return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
    endfunction

    function automatic int lane_val(input int k);
        logic signed [AW-1:0] v;
        v = sample_o[k*AW +: AW];
        return int'(v);
    endfunction

    task automatic expect_zero(input string tag);
        for (int k = 0; k < LANES; k++) begin
            n_cmp++;
            if (lane_val(k) != 0) begin
                n_bad++;
                $display("FAIL %s lane %0d: got %0d expected 0", tag, k, lane_val(k));
            end
        end
    endtask

    task automatic expect_wave(input logic [PW-1:0] init, input logic [PW-1:0] tune, input int n, input string tag);
        for (int k = 0; k < LANES; k++) begin
            logic [PW-1:0] ph;
            int e, g;
            ph = init + PW'(k + LANES * n) * tune;
            e  = ref_amp(ph);
            g  = lane_val(k);
            n_cmp++;
            if (g - e > 1 || e - g > 1) begin
                n_bad++;
                $display("FAIL %s lane %0d n %0d: got %0d expected %0d", tag, k, n, g, e);
            end
        end
    endtask

    // Sync pulse seen high on p edges; check mute, stretch, seeding and streaming.
    task automatic episode(input int p, input logic [PW-1:0] init, input logic [PW-1:0] tune);
        int ld;
        ld = (p > SMIN) ? p : SMIN;
        @(negedge clk);
        sync_i       = 1'b1;
        tune_i       = tune;
        phase_init_i = init;
        #1;
        expect_zero("R5 same-cycle mute");
        for (int j = 0; j <= ld + RUN; j++) begin
            @(negedge clk);
            if (j < p)       expect_zero("R5 sync held");
            else if (j < ld) expect_zero("R7 stretched sync");
            else if (j == ld) expect_zero("R6 seeding latency");
            else             expect_wave(init, tune, j - ld - 1, "R1 R2 R3 R4 R9");
            if (j == p - 1) sync_i = 1'b0;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        tune_i       = 16'h0123;
        phase_init_i = 16'h0400;
        // R8: reset state is silent
        repeat (3) begin
            @(negedge clk);
            expect_zero("R8 reset");
        end
        rst_n = 1'b1;
        // R8: first edge after release seeds
        @(negedge clk);
        expect_zero("R8 seeding latency");
        for (int n = 0; n < RUN; n++) begin
            @(negedge clk);
            expect_wave(16'h0400, 16'h0123, n, "R8 R2 R3");
        end
        // Directed corners: short, exact, long pulses (R7)
        episode(1, 16'h0000, 16'h0200);
        episode(SMIN - 1, 16'h1000, 16'h0333);
        episode(SMIN, 16'h2345, 16'h0100);
        episode(SMIN + 3, 16'h8000, 16'h0777);
        // R9: seed near full scale wraps through zero
        episode(2, 16'hFFC0, 16'h7000);
        // Near Nyquist and zero tuning word
        episode(1, 16'h0040, 16'h8000);
        episode(5, 16'h3000, 16'h0000);
        // Random mix
        for (int e = 0; e < 24; e++) begin
            int p;
            p = 1 + int'($urandom_range(0, 8));
            episode(p, PW'($urandom), PW'($urandom));
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule